// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block models the command side of a byte-wide parallel NOR flash device. The device sits on a simple bus: address, write data, a write strobe and a read strobe. It holds a small byte array split into equal sectors. Writes are decoded as a multi-cycle command protocol. Two address-qualified unlock writes come first, then a command byte. That command byte selects programming, sector or chip erase, identification, table query, or a bypass mode in which later commands need no unlock.

The active mode decides what a read returns. It can be array contents, identification codes, a fixed query table or a status byte. Programming can only clear bits. An erase forces whole sectors, or the whole array, back to 0xFF. The erase then keeps the device busy for a number of clock cycles set by a parameter. During that time writes are ignored and status reads show a toggling busy pattern. Read data is registered and appears in the cycle after the read strobe.

Top module: `nor_cmd_if`

## Requirements
- R1: After reset the device is in read-array mode with bypass off, every array byte reads 0xFF, and rdata_o is 0x00.
- R2: A command is accepted only after 0xAA written to address 0x555 and then 0x55 written to 0x2AA, followed by the command byte at 0x555. A wrong address or data at either unlock write returns the device to read-array mode. Reads between the unlock writes return array data.
- R3: Command 0xA0 makes the next write program the addressed byte (array address = addr_i[ARR_AW-1:0]) as old AND data. Until the next write, reads return the status byte {~data[7], 7'b1111111}. The write after that is decoded as if from read-array mode.
- R4: Writing 0xF0 returns the device to read-array mode from any unlock or command step. When a program data cycle is pending, 0xF0 is programmed as data instead. During an erase, 0xF0 is ignored like any other write.
- R5: Command 0x90 enters identification mode. A read with addr_i[1]=0 returns the manufacturer code (addr_i[0]=0) or the device code (addr_i[0]=1). A read with addr_i[1]=1 returns 0x00, meaning unprotected. Any write other than 0x98 at 0x55 returns to read-array mode.
- R6: Writing 0x98 at 0x55 from read-array or identification mode enters query mode. A read at address i returns the table byte: 0x10..0x13 hold 0x51 0x52 0x59 0x02, 0x27 holds ARR_AW, 0x2D holds NUM_SECT-1, and any i above 0x30 returns 0x00. Any write leaves query mode for read-array mode.
- R7: The sequence 0x80, a second unlock pair, then 0x30 at any address fills that address's sector (addr_i[ARR_AW-1:SECT_AW]) with 0xFF. Other sectors are left unchanged. The device is then busy for SECT_ERASE_CYC cycles.
- R8: The same sequence ending in 0x10 at 0x555 fills the whole array with 0xFF. The device is then busy for 10*SECT_ERASE_CYC cycles.
- R9: While busy, reads return {1'b0, t, 6'b0}, where t is 0 on the first read after the erase command and inverts on each later read. All writes are ignored. When the busy time ends, the device is in read-array mode.
- R10: Command 0x20 enters bypass mode. In bypass mode a command byte is accepted at any address without unlock writes, and after a program the next write is again taken as a command. Writing 0x00 as a command leaves bypass mode.
- R11: When read and write strobes fall in the same cycle, the read returns the value for the state before that write.
- R12: rdata_o changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address for reads and writes |
| wdata_i | input | 8 | Write data or command byte |
| we_i | input | 1 | Write strobe, one cycle per write |
| re_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Registered read data |

## Verification
A read and a write can land in the same cycle. The interesting case is a read of a byte while its program data cycle is being written, which must return the old contents. The other case is a status poll during erase, where interleaved writes must neither advance the toggle bit nor disturb the busy count. The bench provokes the first by raising both strobes together on the program data cycle. It provokes the second by mixing a reset and an unlock attempt into a cycle-by-cycle status poll during chip erase. Each cycle's expected read is derived from the number of cycles elapsed since the erase command.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [3:0] {
    M_RD, M_UNLK1, M_CMD, M_PGM, M_PSTAT, M_ER0, M_ER1, M_ERCMD,
    M_AUTO, M_CFI, M_BUSY, M_BYP
  } mode_e;

  localparam logic [7:0] K_UNLK_A  = 8'hAA;
  localparam logic [7:0] K_UNLK_B  = 8'h55;
  localparam logic [7:0] K_PROG    = 8'hA0;
  localparam logic [7:0] K_ERSETUP = 8'h80;
  localparam logic [7:0] K_CHIP    = 8'h10;
  localparam logic [7:0] K_SECT    = 8'h30;
  localparam logic [7:0] K_IDENT   = 8'h90;
  localparam logic [7:0] K_BYPASS  = 8'h20;
  localparam logic [7:0] K_QUERY   = 8'h98;
  localparam logic [7:0] K_RESET   = 8'hF0;
  localparam logic [7:0] K_BYPEXIT = 8'h00;

  localparam int unsigned QRY_LAST = 32'h30;

  function automatic logic [7:0] qry_byte(input int unsigned idx, input int unsigned arr_aw,
                                          input int unsigned nsect, input int unsigned sect_aw);
    int unsigned slen;
    slen = 32'd1 << sect_aw;
    qry_byte = 8'h00;
    if (idx <= QRY_LAST) begin
      case (idx)
        32'h10: qry_byte = 8'h51;
        32'h11: qry_byte = 8'h52;
        32'h12: qry_byte = 8'h59;
        32'h13: qry_byte = 8'h02;
        32'h1B: qry_byte = 8'h27;
        32'h1C: qry_byte = 8'h36;
        32'h1F: qry_byte = 8'h07;
        32'h20: qry_byte = 8'h04;
        32'h21: qry_byte = 8'h09;
        32'h22: qry_byte = 8'h0C;
        32'h23: qry_byte = 8'h01;
        32'h24: qry_byte = 8'h04;
        32'h25: qry_byte = 8'h0A;
        32'h26: qry_byte = 8'h0D;
        32'h27: qry_byte = 8'(arr_aw);
        32'h28: qry_byte = 8'h02;
        32'h2C: qry_byte = 8'h01;
        32'h2D: qry_byte = 8'(nsect - 1);
        32'h2E: qry_byte = 8'((nsect - 1) >> 8);
        32'h2F: qry_byte = 8'(slen >> 8);
        32'h30: qry_byte = 8'(slen >> 16);
        default: qry_byte = 8'h00;
      endcase
    end
  endfunction

endpackage

// File: rtl/nor_array.sv
module nor_array
  import nor_pkg::*;
#(
  parameter int unsigned SECT_AW  = 6,
  parameter int unsigned NUM_SECT = 4,
  localparam int unsigned SEL_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int unsigned ARR_AW  = SECT_AW + SEL_W,
  localparam int unsigned DEPTH   = 1 << ARR_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              sect_erase_i,
  input  logic              chip_erase_i,
  input  logic [ARR_AW-1:0] wr_addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ARR_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);

  logic [7:0] mem_q [DEPTH];
  logic [SEL_W-1:0] wr_sect;

  assign wr_sect = wr_addr_i[ARR_AW-1:SECT_AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (chip_erase_i) begin
          mem_q[i] <= 8'hFF;
        end else if (sect_erase_i && (SEL_W'(i >> SECT_AW) == wr_sect)) begin
          mem_q[i] <= 8'hFF;
        end else if (prog_i && (ARR_AW'(i) == wr_addr_i)) begin
          mem_q[i] <= mem_q[i] & wdata_i;
        end
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R3
  prog_clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && !sect_erase_i && !chip_erase_i) |=>
      ((mem_q[$past(wr_addr_i)] & ~$past(mem_q[wr_addr_i])) == 8'h00));

  // R7
  sect_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sect_erase_i |=> (mem_q[{$past(wr_sect), {SECT_AW{1'b0}}}] == 8'hFF) &&
                     (mem_q[{$past(wr_sect), {SECT_AW{1'b1}}}] == 8'hFF));

  // R8
  chip_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_i |=> (mem_q[0] == 8'hFF) && (mem_q[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned SECT_CYC = 1000,
  parameter int unsigned CHIP_CYC = 10000,
  localparam int unsigned CNT_W   = $clog2(CHIP_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output mode_e             mode_o,
  output logic              prog_o,
  output logic              sect_erase_o,
  output logic              chip_erase_o,
  output logic              erase_start_o,
  output logic [7:0]        status_o
);

  mode_e            st_q, st_d;
  logic             byp_q, byp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       stat_q, stat_d;

  logic at_555, at_2aa, at_55, cmd_addr_ok;
  logic rd_path, cmd_path;
  mode_e idle;

  assign at_555      = (addr_i == ADDR_W'(12'h555));
  assign at_2aa      = (addr_i == ADDR_W'(12'h2AA));
  assign at_55       = (addr_i == ADDR_W'(12'h055));
  assign cmd_addr_ok = byp_q || at_555;
  assign idle        = byp_q ? M_BYP : M_RD;
  assign rd_path     = (st_q == M_RD) || (st_q == M_PSTAT && !byp_q);
  assign cmd_path    = (st_q == M_CMD) || (st_q == M_BYP) || (st_q == M_PSTAT && byp_q);

  always_comb begin
    st_d         = st_q;
    byp_d        = byp_q;
    cnt_d        = cnt_q;
    stat_d       = stat_q;
    prog_o       = 1'b0;
    sect_erase_o = 1'b0;
    chip_erase_o = 1'b0;
    if (st_q == M_BUSY) begin
      // writes ignored while erasing
      if (cnt_q == '0) st_d = idle;
      else             cnt_d = cnt_q - 1'b1;
    end else if (we_i) begin
      if (wdata_i == K_RESET && st_q != M_PGM) begin
        st_d = idle;
      end else if (rd_path) begin
        if (at_555 && wdata_i == K_UNLK_A)     st_d = M_UNLK1;
        else if (at_55 && wdata_i == K_QUERY)  st_d = M_CFI;
        else                                   st_d = M_RD;
      end else if (cmd_path) begin
        if (byp_q && wdata_i == K_BYPEXIT) begin
          byp_d = 1'b0;
          st_d  = M_RD;
        end else if (!cmd_addr_ok) begin
          st_d = idle;
        end else begin
          case (wdata_i)
            K_PROG:    st_d = M_PGM;
            K_ERSETUP: st_d = M_ER0;
            K_IDENT:   st_d = M_AUTO;
            K_BYPASS: begin
              byp_d = 1'b1;
              st_d  = M_BYP;
            end
            default:   st_d = idle;
          endcase
        end
      end else begin
        case (st_q)
          M_UNLK1: st_d = (at_2aa && wdata_i == K_UNLK_B) ? M_CMD : M_RD;
          M_PGM: begin
            prog_o = 1'b1;
            stat_d = {~wdata_i[7], 7'h7F};
            st_d   = M_PSTAT;
          end
          M_ER0:   st_d = (at_555 && wdata_i == K_UNLK_A) ? M_ER1 : idle;
          M_ER1:   st_d = (at_2aa && wdata_i == K_UNLK_B) ? M_ERCMD : idle;
          M_ERCMD: begin
            if (wdata_i == K_CHIP && cmd_addr_ok) begin
              chip_erase_o = 1'b1;
              cnt_d        = CNT_W'(CHIP_CYC - 1);
              st_d         = M_BUSY;
            end else if (wdata_i == K_SECT) begin
              sect_erase_o = 1'b1;
              cnt_d        = CNT_W'(SECT_CYC - 1);
              st_d         = M_BUSY;
            end else begin
              st_d = idle;
            end
          end
          M_AUTO:  st_d = (at_55 && wdata_i == K_QUERY) ? M_CFI : idle;
          default: st_d = idle;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_RD;
      byp_q  <= 1'b0;
      cnt_q  <= '0;
      stat_q <= 8'hFF;
    end else begin
      st_q   <= st_d;
      byp_q  <= byp_d;
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
    end
  end

  assign mode_o        = st_q;
  assign status_o      = stat_q;
  assign erase_start_o = sect_erase_o | chip_erase_o;

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == M_BUSY && cnt_q != '0) |=> (st_q == M_BUSY) && $stable(byp_q) && $stable(stat_q));

  // R8
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == M_BUSY) |-> (cnt_q < CNT_W'(CHIP_CYC)));

  // R10
  byp_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == M_BYP && we_i && wdata_i == K_BYPEXIT) |=> (!byp_q && st_q == M_RD));

  // R4
  reset_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i == K_RESET && (st_q == M_UNLK1 || st_q == M_CMD || st_q == M_ER0 ||
     st_q == M_ER1 || st_q == M_ERCMD || st_q == M_AUTO)) |=> (st_q == M_RD || st_q == M_BYP));

endmodule

// File: rtl/nor_rd_mux.sv
module nor_rd_mux
  import nor_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned SECT_AW  = 6,
  parameter int unsigned NUM_SECT = 4,
  parameter int unsigned ARR_AW   = 8,
  parameter logic [7:0]  MFR_ID   = 8'h01,
  parameter logic [7:0]  DEV_ID   = 8'h7E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  mode_e             mode_i,
  input  logic [7:0]        arr_data_i,
  input  logic [7:0]        status_i,
  input  logic              erase_start_i,
  output logic [7:0]        rdata_o
);

  logic [7:0] sel_d, rdata_q;
  logic       tgl_q;

  always_comb begin
    case (mode_i)
      M_AUTO:  sel_d = addr_i[1] ? 8'h00 : (addr_i[0] ? DEV_ID : MFR_ID);
      M_CFI:   sel_d = qry_byte(32'(addr_i), ARR_AW, NUM_SECT, SECT_AW);
      M_PSTAT: sel_d = status_i;
      M_BUSY:  sel_d = {1'b0, tgl_q, 6'b0};
      default: sel_d = arr_data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= 8'h00;
      tgl_q   <= 1'b0;
    end else begin
      if (re_i) rdata_q <= sel_d;
      if (erase_start_i)                  tgl_q <= 1'b0;
      else if (re_i && mode_i == M_BUSY)  tgl_q <= ~tgl_q;
    end
  end

  assign rdata_o = rdata_q;

  // R9
  busy_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && mode_i == M_BUSY) |=> (rdata_o[7] == 1'b0) && (rdata_o[5:0] == 6'b0));

  // R9
  busy_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && mode_i == M_BUSY && $past(re_i) && $past(mode_i) == M_BUSY && !$past(erase_start_i))
      |=> (rdata_o[6] != $past(rdata_o[6])));

  // R12
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

endmodule

// File: rtl/nor_cmd_if.sv
module nor_cmd_if
  import nor_pkg::*;
#(
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned SECT_AW        = 6,
  parameter int unsigned NUM_SECT       = 4,
  parameter int unsigned SECT_ERASE_CYC = 1000,
  parameter logic [7:0]  MFR_ID         = 8'h01,
  parameter logic [7:0]  DEV_ID         = 8'h7E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [7:0]        rdata_o
);

  localparam int unsigned SEL_W          = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam int unsigned ARR_AW         = SECT_AW + SEL_W;
  localparam int unsigned CHIP_ERASE_CYC = 10 * SECT_ERASE_CYC;

  mode_e      mode;
  logic       prog, sect_erase, chip_erase, erase_start;
  logic [7:0] status, arr_data;

  nor_cmd_fsm #(
    .ADDR_W  (ADDR_W),
    .SECT_CYC(SECT_ERASE_CYC),
    .CHIP_CYC(CHIP_ERASE_CYC)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .mode_o       (mode),
    .prog_o       (prog),
    .sect_erase_o (sect_erase),
    .chip_erase_o (chip_erase),
    .erase_start_o(erase_start),
    .status_o     (status)
  );

  nor_array #(
    .SECT_AW (SECT_AW),
    .NUM_SECT(NUM_SECT)
  ) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_i      (prog),
    .sect_erase_i(sect_erase),
    .chip_erase_i(chip_erase),
    .wr_addr_i   (addr_i[ARR_AW-1:0]),
    .wdata_i     (wdata_i),
    .rd_addr_i   (addr_i[ARR_AW-1:0]),
    .rd_data_o   (arr_data)
  );

  nor_rd_mux #(
    .ADDR_W  (ADDR_W),
    .SECT_AW (SECT_AW),
    .NUM_SECT(NUM_SECT),
    .ARR_AW  (ARR_AW),
    .MFR_ID  (MFR_ID),
    .DEV_ID  (DEV_ID)
  ) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .re_i         (re_i),
    .addr_i       (addr_i),
    .mode_i       (mode),
    .arr_data_i   (arr_data),
    .status_i     (status),
    .erase_start_i(erase_start),
    .rdata_o      (rdata_o)
  );

  // R11
  same_cycle_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && we_i && mode == M_PGM) |=> (rdata_o == $past(arr_data)));

endmodule

// File: tb/nor_cmd_if_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_if_tb_top;

  localparam int SAW  = 6;
  localparam int NS   = 4;
  localparam int AAW  = 8;
  localparam int DEP  = 256;
  localparam int SCYC = 20;
  localparam int CCYC = 10 * SCYC;
  localparam logic [7:0] MFR = 8'h01;
  localparam logic [7:0] DEV = 8'h7E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wd = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [7:0]  rdata;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [DEP];

  always #4 clk = ~clk;

  nor_cmd_if #(
    .ADDR_W(12), .SECT_AW(SAW), .NUM_SECT(NS), .SECT_ERASE_CYC(SCYC),
    .MFR_ID(MFR), .DEV_ID(DEV)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wd),
    .we_i(we), .re_i(re), .rdata_o(rdata)
  );

  function automatic logic [7:0] exp_stat(input logic [7:0] d);
    return {~d[7], 7'h7F};
  endfunction

  function automatic logic [7:0] exp_qry(input int idx);
    case (idx)
      16'h10: return 8'h51;
      16'h11: return 8'h52;
      16'h12: return 8'h59;
      16'h13: return 8'h02;
      16'h27: return 8'(AAW);
      16'h2D: return 8'(NS - 1);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    addr = a; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] q);
    addr = a; re = 1'b1;
    @(negedge clk);
    q = rdata; re = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [11:0] a, input logic [7:0] d, input string tag);
    logic [7:0] q;
    unlock();
    wr(12'h555, 8'hA0);
    wr(a, d);
    model[a[7:0]] &= d;
    rd(a, q);
    chk(tag, q, exp_stat(d));
    wr(12'h000, 8'hF0);
  endtask

  task automatic cmp_all(input string tag);
    logic [7:0] q;
    for (int i = 0; i < DEP; i++) begin
      rd(12'(i), q);
      chk(tag, q, model[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=00 exp=01");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q, d, old;
    logic [11:0] a;
    logic t;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < DEP; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata after reset", rdata, 8'h00);
    rd(12'h010, q); chk("R1 array erased", q, 8'hFF);
    rd(12'h0FF, q); chk("R1 array erased", q, 8'hFF);

    // R2 unlock: read between writes, mismatch aborts
    wr(12'h555, 8'hAA);
    rd(12'h000, q); chk("R2 read between unlocks", q, 8'hFF);
    wr(12'h2AA, 8'h54);
    wr(12'h555, 8'h90);
    rd(12'h000, q); chk("R2 bad second unlock", q, 8'hFF);
    wr(12'h554, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
    rd(12'h001, q); chk("R2 bad first unlock", q, 8'hFF);
    unlock(); wr(12'h554, 8'h90);
    rd(12'h001, q); chk("R2 command off address", q, 8'hFF);

    // R3 directed and random programs
    prog(12'h012, 8'h5A, "R3 status bit7 low data");
    prog(12'h012, 8'hF3, "R3 status bit7 high data");
    rd(12'h012, q); chk("R3 bits only clear", q, 8'h52);
    for (int n = 0; n < 40; n++) begin
      a = 12'($urandom % DEP);
      d = 8'($urandom);
      prog(a, d, "R3 random program status");
    end
    cmp_all("R3 readback");

    // R4 reset as program data, and reset from command step
    prog(12'h033, 8'hF0, "R4 F0 as data status");
    rd(12'h033, q); chk("R4 F0 programmed", q, model[8'h33]);
    unlock(); wr(12'h555, 8'hF0); wr(12'h034, 8'h00);
    rd(12'h034, q); chk("R4 F0 aborts command", q, model[8'h34]);
    unlock(); wr(12'h555, 8'h80); wr(12'h555, 8'hF0);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h035, 8'h30);
    rd(12'h035, q); chk("R4 F0 aborts erase setup", q, model[8'h35]);

    // R5 identification
    unlock(); wr(12'h555, 8'h90);
    rd(12'h000, q); chk("R5 manufacturer", q, MFR);
    rd(12'h001, q); chk("R5 device", q, DEV);
    rd(12'h002, q); chk("R5 protect", q, 8'h00);
    rd(12'h003, q); chk("R5 protect odd", q, 8'h00);
    wr(12'h000, 8'h12);
    rd(12'h001, q); chk("R5 exit on write", q, model[1]);

    // R6 query table
    wr(12'h055, 8'h98);
    for (int i = 12'h10; i <= 12'h13; i++) begin
      rd(12'(i), q); chk("R6 signature", q, exp_qry(i));
    end
    rd(12'h027, q); chk("R6 size code", q, exp_qry(16'h27));
    rd(12'h02D, q); chk("R6 sector count", q, exp_qry(16'h2D));
    rd(12'h031, q); chk("R6 beyond table", q, 8'h00);
    rd(12'h110, q); chk("R6 beyond table high", q, 8'h00);
    wr(12'h000, 8'h00);
    rd(12'h011, q); chk("R6 exit on write", q, model[8'h11]);
    unlock(); wr(12'h555, 8'h90); wr(12'h055, 8'h98);
    rd(12'h012, q); chk("R6 entry from ident", q, 8'h59);
    wr(12'h000, 8'hF0);

    // R7 sector erase of sector 2 via address 0x0A5
    unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h0A5, 8'h30);
    for (int i = 128; i < 192; i++) model[i] = 8'hFF;
    t = 1'b0;
    for (int c = 1; c <= SCYC; c++) begin
      rd(12'h0A5, q); chk("R7 sector busy status", q, {1'b0, t, 6'b0});
      t = ~t;
    end
    rd(12'h0A5, q); chk("R7 busy ends", q, 8'hFF);
    cmp_all("R7 sector contents");

    // R10 bypass
    unlock(); wr(12'h555, 8'h20);
    rd(12'h090, q); chk("R10 bypass reads array", q, 8'hFF);
    wr(12'h123, 8'hA0); wr(12'h090, 8'h3C); model[8'h90] &= 8'h3C;
    rd(12'h090, q); chk("R10 bypass program status", q, exp_stat(8'h3C));
    wr(12'h777, 8'hA0); wr(12'h091, 8'hC5); model[8'h91] &= 8'hC5;
    rd(12'h091, q); chk("R10 second bypass program", q, exp_stat(8'hC5));
    wr(12'h000, 8'h00);
    rd(12'h091, q); chk("R10 exit reads array", q, model[8'h91]);
    rd(12'h090, q); chk("R10 first byte", q, model[8'h90]);
    wr(12'h555, 8'hA0); wr(12'h092, 8'h00);
    rd(12'h092, q); chk("R10 no bypass after exit", q, 8'hFF);

    // R11 read and write in the same cycle
    unlock(); wr(12'h555, 8'hA0);
    old = model[8'h12];
    addr = 12'h012; wd = 8'h0F; we = 1'b1; re = 1'b1;
    @(negedge clk);
    q = rdata; we = 1'b0; re = 1'b0;
    chk("R11 read sees pre-write byte", q, old);
    model[8'h12] &= 8'h0F;
    rd(12'h012, q); chk("R11 status after", q, exp_stat(8'h0F));
    wr(12'h000, 8'hF0);
    rd(12'h012, q); chk("R11 programmed", q, model[8'h12]);

    // R12 hold without read strobe
    rd(12'h013, q);
    addr = 12'h0A0;
    repeat (3) @(negedge clk);
    chk("R12 hold", rdata, q);

    // R8 and R9 chip erase with writes during busy
    unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h555, 8'h10);
    for (int i = 0; i < DEP; i++) model[i] = 8'hFF;
    t = 1'b0;
    for (int c = 1; c <= CCYC + 4; c++) begin
      if (c == 50)      wr(12'h555, 8'hF0);
      else if (c == 51) wr(12'h555, 8'hAA);
      else if (c == 52) wr(12'h2AA, 8'h55);
      else if (c == 53) wr(12'h555, 8'hA0);
      else begin
        rd(12'h003, q);
        if (c <= CCYC) begin
          chk("R9 chip busy status", q, {1'b0, t, 6'b0});
          t = ~t;
        end else begin
          chk("R8 chip busy ends", q, 8'hFF);
        end
      end
    end
    wr(12'h003, 8'h00);
    rd(12'h003, q); chk("R9 busy writes ignored", q, 8'hFF);
    rd(12'h010, q); chk("R9 read array after erase", q, 8'hFF);
    cmp_all("R8 whole array");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule